// File: doc/BRIEF.md
# Translation Cache with Debugger Matching Bypass

This block is a small, fully associative cache of page translations. It sits in front of a next-level translation port. A lookup request carries a virtual page number, an instruction/data selector, a flag that marks the request as issued by the debugger, and a flag that shows the core is halted in debug state. On a hit, the block returns the cached physical page in the cycle after it accepts the request. On a miss, it forwards the page to the next level, waits for that level's one-cycle response pulse, returns the answer and stores it in the cache.

A 32-bit control register has two enable bits, one for the instruction side and one for the data side. Clearing a side's bit makes debugger-issued requests made during debug state skip the cache on that side. Such a request never checks the stored entries. It always goes to the next level, and its result is neither stored nor allowed to displace anything. All other traffic uses the cache normally. A full flush input clears every entry.

Top module: `tlb_dbg_bypass`

## Requirements
- R1: After reset the control register reads 0x0000000C. No entry is valid, `req_ready_o` is 1, and `nl_req_valid_o` and `rsp_valid_o` are 0.
- R2: Bit 3 of the control register is the instruction-side match enable and bit 2 is the data-side match enable. Bits [31:4] and [1:0] read as zero and ignore writes.
- R3: When a side is configured as not present, its bit reads zero and ignores writes. With the instruction-side bit absent, instruction lookups obey bit 2.
- R4: A hit asserts `rsp_valid_o` and `rsp_hit_o` with the cached page in the cycle after the request is accepted, and issues no next-level request.
- R5: A miss raises `nl_req_valid_o` with the page number and holds both steady until `nl_req_ready_i`. The response is returned with `rsp_hit_o`=0 in the cycle that `nl_rsp_valid_i` pulses.
- R6: A request with debugger flag 1, debug-state flag 1, and the enable bit of its side at 0 is bypassed. It goes to the next level even when its page is cached.
- R7: A bypassed request stores nothing, evicts nothing and does not move the replacement pointer.
- R8: Requests with the debugger flag or the debug-state flag at 0 use the cache normally, whatever the enable bits hold.
- R9: Non-bypassed misses fill entries in round-robin order. With all 8 entries full, the next fill displaces the oldest one.
- R10: A flush pulse invalidates every entry, so a page that was cached before the flush misses afterwards.
- R11: Only one request is in flight. `req_ready_o` stays 0 from acceptance until the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 32 | Control register write data |
| cfg_rdata_o | output | 32 | Control register read data |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Block idle and able to accept |
| req_vpn_i | input | 20 | Virtual page number |
| req_instr_i | input | 1 | 1 = instruction side, 0 = data side |
| req_dbg_i | input | 1 | Request issued by the debugger |
| req_halt_i | input | 1 | Core is in debug state |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_hit_o | output | 1 | Response came from the cache |
| rsp_ppn_o | output | 20 | Physical page number |
| nl_req_valid_o | output | 1 | Next-level request valid |
| nl_req_ready_i | input | 1 | Next level accepts the request |
| nl_req_vpn_o | output | 20 | Page sent to the next level |
| nl_rsp_valid_i | input | 1 | Next-level response pulse |
| nl_rsp_ppn_i | input | 20 | Next-level physical page |

## Verification
The assertions rely on several conditions at the ports. The requester raises `req_valid_i` only while `req_ready_o` is high. The next level pulses `nl_rsp_valid_i` only after it has accepted a request. `nl_req_ready_i` is high only while a request is pending. The stimulus keeps to these rules. Every lookup is a one-cycle valid pulse issued after the previous response. The modelled next level waits a programmable number of cycles before accepting a pending request, and answers exactly once per handshake. A second instance, built without the instruction-side bit, is driven by a plain requester whose ready input is always high.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int CFG_W    = 32;
  localparam int CFG_IBIT = 3;
  localparam int CFG_DBIT = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_NL_REQ,
    ST_NL_WAIT
  } tlb_state_e;
endpackage

// File: rtl/tlb_cfg_reg.sv
module tlb_cfg_reg
  import tlb_pkg::*;
#(
  parameter bit HAS_ISIDE = 1'b1,
  parameter bit HAS_DSIDE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] rdata_o,
  output logic             i_match_o,
  output logic             d_match_o
);
  localparam logic [1:0] IMPL = {HAS_ISIDE, HAS_DSIDE};

  logic i_bit, d_bit;

  generate
    if (HAS_ISIDE) begin : g_ibit
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)   q <= 1'b1;
        else if (we_i) q <= wdata_i[CFG_IBIT];
      assign i_bit = q;
    end else begin : g_no_ibit
      assign i_bit = 1'b0;
    end

    if (HAS_DSIDE) begin : g_dbit
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)   q <= 1'b1;
        else if (we_i) q <= wdata_i[CFG_DBIT];
      assign d_bit = q;
    end else begin : g_no_dbit
      assign d_bit = 1'b0;
    end
  endgenerate

  always_comb begin
    rdata_o           = '0;
    rdata_o[CFG_IBIT] = i_bit;
    rdata_o[CFG_DBIT] = d_bit;
  end

  // absent side: data follows "normal", instruction follows data side
  assign d_match_o = HAS_DSIDE ? d_bit : 1'b1;
  assign i_match_o = HAS_ISIDE ? i_bit : d_match_o;

  assert_cfg_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_i && rst_ni) |->
      rdata_o[CFG_IBIT:CFG_DBIT] == ($past(wdata_i[CFG_IBIT:CFG_DBIT]) & IMPL));
endmodule

// File: rtl/tlb_array.sv
module tlb_array #(
  parameter int NUM_ENTRIES = 8,
  parameter int VPN_W       = 20,
  parameter int PPN_W       = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [VPN_W-1:0] lookup_vpn_i,
  output logic             hit_o,
  output logic [PPN_W-1:0] hit_ppn_o,
  input  logic             fill_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i
);
  localparam int PTR_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic [NUM_ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]       vpn_q [NUM_ENTRIES];
  logic [PPN_W-1:0]       ppn_q [NUM_ENTRIES];
  logic [PTR_W-1:0]       ptr_q;
  logic [NUM_ENTRIES-1:0] hit_vec;

  generate
    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
      assign hit_vec[e] = valid_q[e] && (vpn_q[e] == lookup_vpn_i);

      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          vpn_q[e] <= '0;
          ppn_q[e] <= '0;
        end else if (fill_i && !flush_i && ptr_q == PTR_W'(e)) begin
          vpn_q[e] <= fill_vpn_i;
          ppn_q[e] <= fill_ppn_i;
        end
    end
  endgenerate

  always_comb begin
    hit_ppn_o = '0;
    for (int e = 0; e < NUM_ENTRIES; e++)
      if (hit_vec[e]) hit_ppn_o = hit_ppn_o | ppn_q[e];
  end
  assign hit_o = |hit_vec;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else if (fill_i) begin
      valid_q[ptr_q] <= 1'b1;
      ptr_q <= (ptr_q == PTR_W'(NUM_ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end

  assert_hit_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
  assert_no_change_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fill_i && !flush_i |=> $stable(valid_q) && $stable(ptr_q));
  assert_flush_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> valid_q == '0);
endmodule

// File: rtl/tlb_dbg_bypass.sv
module tlb_dbg_bypass
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int VPN_W       = 20,
  parameter int PPN_W       = 20,
  parameter bit HAS_ISIDE   = 1'b1,
  parameter bit HAS_DSIDE   = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             cfg_we_i,
  input  logic [31:0]      cfg_wdata_i,
  output logic [31:0]      cfg_rdata_o,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VPN_W-1:0] req_vpn_i,
  input  logic             req_instr_i,
  input  logic             req_dbg_i,
  input  logic             req_halt_i,
  output logic             rsp_valid_o,
  output logic             rsp_hit_o,
  output logic [PPN_W-1:0] rsp_ppn_o,
  output logic             nl_req_valid_o,
  input  logic             nl_req_ready_i,
  output logic [VPN_W-1:0] nl_req_vpn_o,
  input  logic             nl_rsp_valid_i,
  input  logic [PPN_W-1:0] nl_rsp_ppn_i
);
  tlb_state_e       state_q, state_d;
  logic [VPN_W-1:0] vpn_q;
  logic             bypass_q;
  logic             i_match, d_match, side_match, accept;
  logic             arr_hit, cache_hit, fill;
  logic [PPN_W-1:0] arr_ppn;

  tlb_cfg_reg #(.HAS_ISIDE(HAS_ISIDE), .HAS_DSIDE(HAS_DSIDE)) i_cfg (
    .clk_i, .rst_ni,
    .we_i      (cfg_we_i),
    .wdata_i   (cfg_wdata_i),
    .rdata_o   (cfg_rdata_o),
    .i_match_o (i_match),
    .d_match_o (d_match)
  );

  tlb_array #(.NUM_ENTRIES(NUM_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) i_array (
    .clk_i, .rst_ni,
    .flush_i,
    .lookup_vpn_i (vpn_q),
    .hit_o        (arr_hit),
    .hit_ppn_o    (arr_ppn),
    .fill_i       (fill),
    .fill_vpn_i   (vpn_q),
    .fill_ppn_i   (nl_rsp_ppn_i)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign side_match  = req_instr_i ? i_match : d_match;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      vpn_q    <= '0;
      bypass_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        vpn_q    <= req_vpn_i;
        bypass_q <= req_dbg_i && req_halt_i && !side_match;
      end
    end

  assign cache_hit = (state_q == ST_LOOKUP) && arr_hit && !bypass_q;
  assign fill      = (state_q == ST_NL_WAIT) && nl_rsp_valid_i && !bypass_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept) state_d = ST_LOOKUP;
      ST_LOOKUP:  state_d = cache_hit ? ST_IDLE : ST_NL_REQ;
      ST_NL_REQ:  if (nl_req_ready_i) state_d = ST_NL_WAIT;
      ST_NL_WAIT: if (nl_rsp_valid_i) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  assign nl_req_valid_o = (state_q == ST_NL_REQ);
  assign nl_req_vpn_o   = vpn_q;
  assign rsp_valid_o    = cache_hit || ((state_q == ST_NL_WAIT) && nl_rsp_valid_i);
  assign rsp_hit_o      = cache_hit;
  assign rsp_ppn_o      = cache_hit ? arr_ppn : nl_rsp_ppn_i;

  assert_hit_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> $past(req_valid_i && req_ready_o));
  assert_nl_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nl_req_valid_o && !nl_req_ready_i |=> nl_req_valid_o && $stable(nl_req_vpn_o));
  assert_bypass_no_hit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && bypass_q |-> !rsp_hit_o);
  assert_single_outstanding_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_valid_i && req_ready_o) |-> !req_ready_o);
  assert_nl_only_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nl_req_valid_o |-> !req_ready_o);
endmodule

// File: tb/test_tlb_dbg_bypass.sv
module test_tlb_dbg_bypass;
  localparam time PERIOD = 10ns;
  localparam logic [19:0] KEY0 = 20'h5A5A5;
  localparam logic [19:0] KEY1 = 20'h0F0F0;

  typedef struct packed {
    logic [3:0]  cfg;
    logic [19:0] vpn;
    logic        instr;
    logic        dbg;
    logic        halt;
    logic        hit;
  } vec_t;

  // cfg nibble: bit3 = instruction enable, bit2 = data enable
  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{4'hC, 20'h00010, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 miss fills
    '{4'hC, 20'h00010, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 hit
    '{4'hC, 20'h00010, 1'b1, 1'b1, 1'b1, 1'b1}, // R6 enabled -> hit
    '{4'h8, 20'h00010, 1'b0, 1'b1, 1'b1, 1'b0}, // R6 data bypass
    '{4'h8, 20'h00010, 1'b0, 1'b1, 1'b0, 1'b1}, // R8 not halted
    '{4'h8, 20'h00010, 1'b0, 1'b0, 1'b1, 1'b1}, // R8 not debugger
    '{4'h8, 20'h00010, 1'b1, 1'b1, 1'b1, 1'b1}, // R2 instr side enabled
    '{4'h4, 20'h00010, 1'b1, 1'b1, 1'b1, 1'b0}, // R2 instr bypass
    '{4'h4, 20'h00020, 1'b1, 1'b1, 1'b1, 1'b0}, // R7 bypass miss, no fill
    '{4'hC, 20'h00020, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 still misses
    '{4'hC, 20'h00020, 1'b1, 1'b0, 1'b0, 1'b1}  // R4 hit after fill
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0, cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        req_valid = 1'b0, req_ready;
  logic [19:0] req_vpn = '0;
  logic        req_instr = 1'b0, req_dbg = 1'b0, req_halt = 1'b0;
  logic        rsp_valid, rsp_hit;
  logic [19:0] rsp_ppn;
  logic        nl_req_valid, nl_req_ready = 1'b0;
  logic [19:0] nl_req_vpn;
  logic        nl_rsp_valid = 1'b0;
  logic [19:0] nl_rsp_ppn = '0;

  // second instance without the instruction-side bit
  logic        u_cfg_we = 1'b0;
  logic [31:0] u_cfg_wdata = '0, u_cfg_rdata;
  logic        u_req_valid = 1'b0, u_req_ready;
  logic [19:0] u_req_vpn = '0;
  logic        u_req_instr = 1'b0, u_req_dbg = 1'b0, u_req_halt = 1'b0;
  logic        u_rsp_valid, u_rsp_hit;
  logic [19:0] u_rsp_ppn;
  logic        u_nl_req_valid;
  logic [19:0] u_nl_req_vpn;
  logic        u_nl_rsp_valid = 1'b0;
  logic [19:0] u_nl_rsp_ppn = '0;

  int          checks = 0, failures = 0, nl_count = 0, nl_delay = 1;
  logic [19:0] key = KEY0;

  always #(PERIOD/2) clk = ~clk;

  tlb_dbg_bypass i_tlb_dbg_bypass (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vpn_i(req_vpn),
    .req_instr_i(req_instr), .req_dbg_i(req_dbg), .req_halt_i(req_halt),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_ppn_o(rsp_ppn),
    .nl_req_valid_o(nl_req_valid), .nl_req_ready_i(nl_req_ready),
    .nl_req_vpn_o(nl_req_vpn), .nl_rsp_valid_i(nl_rsp_valid), .nl_rsp_ppn_i(nl_rsp_ppn)
  );

  tlb_dbg_bypass #(.HAS_ISIDE(1'b0)) i_tlb_dbg_bypass_uni (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(1'b0),
    .cfg_we_i(u_cfg_we), .cfg_wdata_i(u_cfg_wdata), .cfg_rdata_o(u_cfg_rdata),
    .req_valid_i(u_req_valid), .req_ready_o(u_req_ready), .req_vpn_i(u_req_vpn),
    .req_instr_i(u_req_instr), .req_dbg_i(u_req_dbg), .req_halt_i(u_req_halt),
    .rsp_valid_o(u_rsp_valid), .rsp_hit_o(u_rsp_hit), .rsp_ppn_o(u_rsp_ppn),
    .nl_req_valid_o(u_nl_req_valid), .nl_req_ready_i(1'b1),
    .nl_req_vpn_o(u_nl_req_vpn), .nl_rsp_valid_i(u_nl_rsp_valid), .nl_rsp_ppn_i(u_nl_rsp_ppn)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic write_cfg(input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic do_lookup(input logic [19:0] vpn, input logic instr, input logic dbg,
                           input logic halt, input logic exp_hit,
                           input logic [19:0] exp_ppn, input string tag);
    int lat = 0, n0;
    logic rdy_bad = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_vpn = vpn; req_instr = instr; req_dbg = dbg; req_halt = halt;
    n0 = nl_count;
    @(negedge clk); req_valid = 1'b0;
    #(PERIOD/4);
    while (!rsp_valid && lat < 200) begin
      if (req_ready) rdy_bad = 1'b1;
      #(PERIOD); lat++;
    end
    check({tag, " hit"}, rsp_hit, exp_hit);
    check({tag, " ppn"}, rsp_ppn, exp_ppn);
    check({tag, " nl requests"}, nl_count - n0, exp_hit ? 0 : 1);
    if (exp_hit) check("R4 hit latency", lat, 0);
    else         check("R11 ready low while pending", rdy_bad, 1'b0);
  endtask

  // next-level model
  initial begin
    logic [19:0] cap;
    forever begin
      @(negedge clk);
      if (nl_req_valid) begin
        cap = nl_req_vpn;
        for (int i = 0; i < nl_delay; i++) begin
          @(negedge clk);
          check("R5 request held", {nl_req_valid, nl_req_vpn}, {1'b1, cap});
        end
        nl_req_ready = 1'b1; nl_count++;
        @(negedge clk);
        nl_req_ready = 1'b0; nl_rsp_valid = 1'b1; nl_rsp_ppn = cap ^ key;
        @(negedge clk);
        nl_rsp_valid = 1'b0;
      end
    end
  end

  task automatic u_lookup(input logic [19:0] vpn, input logic instr, input logic dbg,
                          input logic halt, input logic exp_hit, input string tag);
    @(negedge clk);
    u_req_valid = 1'b1; u_req_vpn = vpn; u_req_instr = instr; u_req_dbg = dbg; u_req_halt = halt;
    @(negedge clk); u_req_valid = 1'b0;
    #(PERIOD/4);
    check(tag, u_rsp_valid && u_rsp_hit, exp_hit);
    if (!u_rsp_valid) begin
      @(negedge clk);
      @(negedge clk);
      u_nl_rsp_valid = 1'b1; u_nl_rsp_ppn = vpn ^ KEY1;
      #(PERIOD/4);
      check({tag, " nl answer"}, {u_rsp_valid, u_rsp_ppn}, {1'b1, vpn ^ KEY1});
      @(negedge clk); u_nl_rsp_valid = 1'b0;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 cfg reset", cfg_rdata, 32'h0000_000C);
    check("R1 ready", req_ready, 1'b1);
    check("R1 idle outputs", {nl_req_valid, rsp_valid}, 2'b00);
    check("R3 cfg reset uni", u_cfg_rdata, 32'h0000_0004);

    // R2 reserved bits
    write_cfg(32'hFFFF_FFF3);
    check("R2 reserved ignored", cfg_rdata, 32'h0000_0000);
    write_cfg(32'hFFFF_FFFF);
    check("R2 enable bits only", cfg_rdata, 32'h0000_000C);

    // vector table
    for (int v = 0; v < NV; v++) begin
      write_cfg({28'h0, VECS[v].cfg});
      do_lookup(VECS[v].vpn, VECS[v].instr, VECS[v].dbg, VECS[v].halt,
                VECS[v].hit, VECS[v].vpn ^ KEY0, $sformatf("vec%0d", v));
    end

    // R10 flush
    write_cfg(32'hC);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    do_lookup(20'h00010, 1'b0, 1'b0, 1'b0, 1'b0, 20'h00010 ^ KEY0, "R10 miss after flush");
    for (int a = 1; a < 8; a++)
      do_lookup(20'h00100 + 20'(a), 1'b0, 1'b0, 1'b0, 1'b0, (20'h00100 + 20'(a)) ^ KEY0, "R9 fill");

    // R6/R7 bypass with a full table
    nl_delay = 3;
    write_cfg(32'h8);
    do_lookup(20'h00200, 1'b0, 1'b1, 1'b1, 1'b0, 20'h00200 ^ KEY0, "R6 bypass miss");
    key = KEY1;
    do_lookup(20'h00010, 1'b0, 1'b1, 1'b1, 1'b0, 20'h00010 ^ KEY1, "R6 bypass cached page");
    do_lookup(20'h00010, 1'b0, 1'b0, 1'b0, 1'b1, 20'h00010 ^ KEY0, "R7 entry kept");
    do_lookup(20'h00200, 1'b0, 1'b0, 1'b0, 1'b0, 20'h00200 ^ KEY1, "R7 not stored");
    do_lookup(20'h00102, 1'b0, 1'b0, 1'b0, 1'b1, 20'h00102 ^ KEY0, "R9 newer kept");
    do_lookup(20'h00010, 1'b0, 1'b0, 1'b0, 1'b0, 20'h00010 ^ KEY1, "R9 oldest evicted");
    do_lookup(20'h00101, 1'b0, 1'b0, 1'b0, 1'b0, 20'h00101 ^ KEY1, "R9 next evicted");
    nl_delay = 0;
    do_lookup(20'h00200, 1'b0, 1'b0, 1'b0, 1'b1, 20'h00200 ^ KEY1, "R4 refilled hit");

    // R3 instance without instruction-side bit
    @(negedge clk); u_cfg_we = 1'b1; u_cfg_wdata = 32'hFFFF_FFFF;
    @(negedge clk); u_cfg_we = 1'b0;
    check("R3 absent bit reads zero", u_cfg_rdata, 32'h0000_0004);
    u_lookup(20'h00333, 1'b1, 1'b0, 1'b0, 1'b0, "R3 uni miss");
    u_lookup(20'h00333, 1'b1, 1'b1, 1'b1, 1'b1, "R3 uni hit with bit2 set");
    @(negedge clk); u_cfg_we = 1'b1; u_cfg_wdata = 32'h0000_0008;
    @(negedge clk); u_cfg_we = 1'b0;
    check("R3 absent bit ignores write", u_cfg_rdata, 32'h0000_0000);
    u_lookup(20'h00333, 1'b1, 1'b1, 1'b1, 1'b0, "R3 instr follows bit2 bypass");
    u_lookup(20'h00333, 1'b1, 1'b0, 1'b0, 1'b1, "R3 normal still hits");

    repeat (2) @(negedge clk);
    summary();
  end
endmodule